// File: doc/BRIEF.md
# Grouped Interrupt Flag Controller

This block collects the interrupt sources of a small microcontroller into seven request lines, numbered 0 to 6. Each line has an enable bit and a primary pending flag. A line raises its request while both are set. The primary flag of a line clears when the processor acknowledges the vector for that line. Lines 0, 1, 3 and 5 come from external pins. Lines 2, 4 and 6 are each driven by a group of internal event sources. Every source in a group has its own secondary flag, which sets when its event fires and its enable is on. The line then sees one edge on the OR of the group's flags.

Software clears secondary flags by writing a zero to the flag's bit position. A one written to a flag bit has no effect. So a byte that is all ones except for a single zero clears exactly one flag and leaves the others alone. A wake status flag shares the same clear rule but is not tied to any line. When a hardware set and a software clear hit the same flag in the same cycle, the set wins. The block is a plain register-and-flag circuit with no data stream. Its write port, acknowledge input and status outputs have no back-pressure: a write or an acknowledge takes effect at the clock edge where its strobe is high.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset all primary flags, secondary flags, line enables and source enables are 0, the requests are 0, and both polarity bits are 1 (falling edge).
- R2: `irq_req[i]` is 1 exactly when line enable bit i (register 0, bits 6:0) and primary flag i are both 1. Clearing the enable hides the request but keeps the flag.
- R3: An acknowledge with `ack_line`=i clears primary flag i at that edge and touches no other flag.
- R4: A write to register 3 clears each secondary flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged. Flag bits: 0 transfer-busy, 1 one-second, 2 collision 0, 3 collision 1, 4 lock rise, 5 lock fall, 6 wake.
- R5: A secondary flag sets only while its enable is 1. Register 1 holds the enables: bit 0 transfer-busy, bit 1 one-second, bit 2 both collisions, bit 3 both lock events. The wake flag sets on `wake_evt` regardless of any enable.
- R6: When a set and a clear hit the same flag at the same edge, the flag ends at 1. This holds both for a secondary set against a write of 0, and for a primary set against an acknowledge.
- R7: Line 6 fires on a rising edge of (transfer-busy flag OR one-second flag). If one of these flags is set while the other is still pending, no further line-6 request arrives until both have been cleared.
- R8: Register 2, bit 0 selects the active edge for line 2, and bit 1 selects it for line 3 (1 = falling, 0 = rising). Line 2 sees the inverted OR of the collision flags, so the falling setting fires when a flag sets and the rising setting fires when the last flag clears.
- R9: A rising edge on `lock_in` sets the lock-rise flag and a falling edge sets the lock-fall flag, each two edges after the change. Line 4 fires on a rising edge of their OR.
- R10: Lines 0 and 1 fire on a rising edge of their pin. Line 5's pin is inverted before detection, so it fires on a falling pin edge.
- R11: A primary flag sets at the second clock edge after its source signal changes, whether that source is a pin or a secondary-flag OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 line enable, 1 source enable, 2 polarity, 3 flag clear) |
| wr_data | input | 8 | Write data byte |
| ack_valid | input | 1 | Vector acknowledge pulse |
| ack_line | input | 3 | Line being acknowledged |
| ext0_in | input | 1 | Line 0 pin |
| ext1_in | input | 1 | Line 1 pin |
| ext3_in | input | 1 | Line 3 pin |
| ext5_n_in | input | 1 | Line 5 pin, active low |
| xfer_evt | input | 1 | Transfer-busy event pulse |
| rtc_evt | input | 1 | One-second timer event pulse |
| col_evt | input | 2 | Collision event pulses 0 and 1 |
| lock_in | input | 1 | Clock-lock status level |
| wake_evt | input | 1 | Wake-timer timeout event pulse |
| irq_req | output | 7 | Per-line request |
| pend_flags | output | 7 | Primary pending flags |
| src_flags | output | 7 | Secondary flags, wake in bit 6 |

## Verification
Every flag is visible directly on `pend_flags` or `src_flags`, so a wrong flag state shows at the ports on the edge where it goes wrong. A fault in an edge detector's sample registers is different: it appears only two edges later, as a missing or extra primary flag. A wrongly sampled group OR shows up as a line 6 that fires twice instead of staying locked out. The bench therefore samples each primary flag at exactly the edge where R11 says it changes. It also checks the locked-out window over several cycles, so a late or repeated edge is caught.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NLINES  = 7;
  localparam int NSRC    = 7;
  localparam int ADDR_W  = 2;
  localparam int LINE_W  = $clog2(NLINES);
  localparam int BYTE_W  = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_LINE_EN = 2'd0,
    REG_SRC_EN  = 2'd1,
    REG_POL     = 2'd2,
    REG_FLAGS   = 2'd3
  } reg_sel_e;

  localparam int F_XFER  = 0;
  localparam int F_RTC   = 1;
  localparam int F_COL0  = 2;
  localparam int F_COL1  = 3;
  localparam int F_LRISE = 4;
  localparam int F_LFALL = 5;
  localparam int F_WAKE  = 6;

  localparam int E_XFER = 0;
  localparam int E_RTC  = 1;
  localparam int E_COL  = 2;
  localparam int E_LOCK = 3;
  localparam int NEN    = 4;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic [W-1:0] sig,
  input  logic [W-1:0] fall_sel,
  output logic [W-1:0] pulse
);
  logic [W-1:0] s_cur, s_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cur  <= '0;
      s_prev <= '0;
    end else begin
      s_cur  <= sig;
      s_prev <= s_cur;
    end
  end

  always_comb begin
    pulse = {W{arm}} & ((fall_sel & s_prev & ~s_cur) |
                        (~fall_sel & ~s_prev & s_cur));
  end
endmodule

// File: rtl/irq_src_flags.sv
module irq_src_flags #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic         clr_we,
  input  logic [N-1:0] keep_mask,
  output logic [N-1:0] flags
);
  logic [N-1:0] kept;

  always_comb kept = clr_we ? (flags & keep_mask) : flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= kept | set_evt;
  end
endmodule

// File: rtl/irq_line_pend.sv
module irq_line_pend #(
  parameter int N = 7,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set_line,
  input  logic          ack_valid,
  input  logic [LW-1:0] ack_line,
  output logic [N-1:0]  pend
);
  logic [N-1:0] ack_mask;

  for (genvar i = 0; i < N; i++) begin : g_ack
    assign ack_mask[i] = ack_valid && (ack_line == LW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~ack_mask) | set_line;
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                ack_valid,
  input  logic [LINE_W-1:0]   ack_line,
  input  logic                ext0_in,
  input  logic                ext1_in,
  input  logic                ext3_in,
  input  logic                ext5_n_in,
  input  logic                xfer_evt,
  input  logic                rtc_evt,
  input  logic [1:0]          col_evt,
  input  logic                lock_in,
  input  logic                wake_evt,
  output logic [NLINES-1:0]   irq_req,
  output logic [NLINES-1:0]   pend_flags,
  output logic [NSRC-1:0]     src_flags
);
  logic [NLINES-1:0] line_en;
  logic [NEN-1:0]    src_en;
  logic [1:0]        pol_fall;
  logic [1:0]        arm_sr;
  logic [1:0]        lock_pulse;
  logic [NSRC-1:0]   src_set;
  logic [NLINES-1:0] line_sig, line_fall, line_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_en  <= '0;
      src_en   <= '0;
      pol_fall <= 2'b11;
      arm_sr   <= '0;
    end else begin
      arm_sr <= {arm_sr[0], 1'b1};
      if (wr_en) begin
        case (reg_sel_e'(wr_addr))
          REG_LINE_EN: line_en  <= wr_data[NLINES-1:0];
          REG_SRC_EN:  src_en   <= wr_data[NEN-1:0];
          REG_POL:     pol_fall <= wr_data[1:0];
          default: ;
        endcase
      end
    end
  end

  irq_edge_det #(.W(2)) u_lock_det (
    .clk(clk), .rst_n(rst_n), .arm(arm_sr[1]),
    .sig({lock_in, lock_in}), .fall_sel(2'b10), .pulse(lock_pulse)
  );

  always_comb begin
    src_set          = '0;
    src_set[F_XFER]  = xfer_evt      & src_en[E_XFER];
    src_set[F_RTC]   = rtc_evt       & src_en[E_RTC];
    src_set[F_COL0]  = col_evt[0]    & src_en[E_COL];
    src_set[F_COL1]  = col_evt[1]    & src_en[E_COL];
    src_set[F_LRISE] = lock_pulse[0] & src_en[E_LOCK];
    src_set[F_LFALL] = lock_pulse[1] & src_en[E_LOCK];
    src_set[F_WAKE]  = wake_evt;
  end

  irq_src_flags #(.N(NSRC)) u_src_flags (
    .clk(clk), .rst_n(rst_n), .set_evt(src_set),
    .clr_we(wr_en && (reg_sel_e'(wr_addr) == REG_FLAGS)),
    .keep_mask(wr_data[NSRC-1:0]), .flags(src_flags)
  );

  always_comb begin
    line_sig    = {src_flags[F_XFER] | src_flags[F_RTC],
                   ~ext5_n_in,
                   src_flags[F_LRISE] | src_flags[F_LFALL],
                   ext3_in,
                   ~(src_flags[F_COL0] | src_flags[F_COL1]),
                   ext1_in,
                   ext0_in};
    line_fall    = '0;
    line_fall[2] = pol_fall[0];
    line_fall[3] = pol_fall[1];
  end

  irq_edge_det #(.W(NLINES)) u_line_det (
    .clk(clk), .rst_n(rst_n), .arm(arm_sr[1]),
    .sig(line_sig), .fall_sel(line_fall), .pulse(line_pulse)
  );

  irq_line_pend #(.N(NLINES), .LW(LINE_W)) u_line_pend (
    .clk(clk), .rst_n(rst_n), .set_line(line_pulse),
    .ack_valid(ack_valid), .ack_line(ack_line), .pend(pend_flags)
  );

  assign irq_req = line_en & pend_flags;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk
  import irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic              ack_valid,
  input logic              wake_evt,
  input logic [NLINES-1:0] irq_req,
  input logic [NLINES-1:0] pend_flags,
  input logic [NSRC-1:0]   src_flags
);
  assert_req_needs_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~pend_flags) == '0);

  assert_pend_falls_on_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend_flags) & ~pend_flags)) |-> $past(ack_valid));

  assert_one_pend_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones($past(pend_flags) & ~pend_flags) <= 1);

  assert_flag_falls_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(src_flags) & ~src_flags)) |-> $past(wr_en && wr_addr == REG_FLAGS));

  assert_ones_keep_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_flags) & ~src_flags & $past(wr_data[NSRC-1:0])) == '0);

  assert_wake_needs_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_flags[F_WAKE]) |-> $past(wake_evt));

  assert_line6_from_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_flags[6]) |-> $past(src_flags[F_XFER] | src_flags[F_RTC], 2));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .ack_valid(ack_valid), .wake_evt(wake_evt),
  .irq_req(irq_req), .pend_flags(pend_flags), .src_flags(src_flags)
);

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_line = '0;
  logic       ext0_in = 1'b0, ext1_in = 1'b0, ext3_in = 1'b0, ext5_n_in = 1'b1;
  logic       xfer_evt = 1'b0, rtc_evt = 1'b0, lock_in = 1'b0, wake_evt = 1'b0;
  logic [1:0] col_evt = '0;
  logic [6:0] irq_req, pend_flags, src_flags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [6:0] e_en = '0;

  string      q_tag[$];
  logic [13:0] q_exp[$];

  irq_flag_ctrl u_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ack_valid(ack_valid), .ack_line(ack_line),
    .ext0_in(ext0_in), .ext1_in(ext1_in), .ext3_in(ext3_in),
    .ext5_n_in(ext5_n_in), .xfer_evt(xfer_evt), .rtc_evt(rtc_evt),
    .col_evt(col_evt), .lock_in(lock_in), .wake_evt(wake_evt),
    .irq_req(irq_req), .pend_flags(pend_flags), .src_flags(src_flags)
  );

  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_st(input string tag, input logic [6:0] p, input logic [6:0] f);
    q_tag.push_back(tag);
    q_exp.push_back({p, f});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
    if (a == 2'd0) e_en = d[6:0];
  endtask

  task automatic ack(input logic [2:0] l);
    ack_valid = 1'b1; ack_line = l;
    tick(1);
    ack_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    while (q_tag.size() > 0) begin
      string t;
      logic [13:0] e;
      logic [6:0] er;
      t = q_tag.pop_front();
      e = q_exp.pop_front();
      er = e[13:7] & e_en;
      checks++;
      if (pend_flags !== e[13:7] || src_flags !== e[6:0] || irq_req !== er) begin
        failures++;
        $display("FAIL %s pend=%h flags=%h req=%h expected pend=%h flags=%h req=%h",
                 t, pend_flags, src_flags, irq_req, e[13:7], e[6:0], er);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick(3);
    expect_st("R1 reset state", 7'h00, 7'h00);
    wr(2'd0, 8'h7F);
    wr(2'd1, 8'h0F);

    ext0_in = 1'b1; tick(1);
    expect_st("R11 line0 not before second edge", 7'h00, 7'h00);
    tick(1);
    expect_st("R10 line0 rising pin", 7'h01, 7'h00);
    ext0_in = 1'b0;
    ack(3'd0);
    expect_st("R3 ack clears line0", 7'h00, 7'h00);

    ext1_in = 1'b1; tick(2);
    expect_st("R10 line1 rising pin", 7'h02, 7'h00);
    wr(2'd0, 8'h7D);
    expect_st("R2 disabled line keeps flag", 7'h02, 7'h00);
    wr(2'd0, 8'h7F);
    expect_st("R2 re-enabled line requests", 7'h02, 7'h00);
    ext1_in = 1'b0;
    ack(3'd1);

    ext5_n_in = 1'b0; tick(2);
    expect_st("R10 line5 falling pin", 7'h20, 7'h00);
    ack(3'd5);
    ext5_n_in = 1'b1; tick(3);
    expect_st("R10 line5 rising pin ignored", 7'h00, 7'h00);

    ext3_in = 1'b1; tick(3);
    expect_st("R8 line3 rising ignored when falling set", 7'h00, 7'h00);
    ext3_in = 1'b0; tick(2);
    expect_st("R8 line3 falling edge", 7'h08, 7'h00);
    ack(3'd3);
    wr(2'd2, 8'h01);
    ext3_in = 1'b1; tick(2);
    expect_st("R8 line3 rising edge selected", 7'h08, 7'h00);
    ack(3'd3);
    ext3_in = 1'b0; tick(3);
    expect_st("R8 line3 falling ignored when rising set", 7'h00, 7'h00);
    wr(2'd2, 8'h03);

    col_evt = 2'b01; tick(1); col_evt = 2'b00;
    expect_st("R5 collision0 flag sets", 7'h00, 7'h04);
    wr(2'd3, 8'hFF);
    expect_st("R4 written ones keep flag", 7'h00, 7'h04);
    wr(2'd3, 8'hFB);
    expect_st("R4 mask zero clears flag, R8 line2 fires", 7'h04, 7'h00);
    ack(3'd2);
    tick(3);
    expect_st("R8 line2 no request on clear when falling", 7'h00, 7'h00);
    wr(2'd2, 8'h02);
    col_evt = 2'b10; tick(1); col_evt = 2'b00;
    tick(3);
    expect_st("R8 line2 no request on set when rising", 7'h00, 7'h08);
    wr(2'd3, 8'hF7);
    tick(2);
    expect_st("R8 line2 fires when last flag clears", 7'h04, 7'h00);
    ack(3'd2);
    wr(2'd2, 8'h03);

    wr(2'd1, 8'h0E);
    xfer_evt = 1'b1; tick(1); xfer_evt = 1'b0;
    tick(3);
    expect_st("R5 disabled source does not set", 7'h00, 7'h00);
    wr(2'd1, 8'h00);
    wake_evt = 1'b1; tick(1); wake_evt = 1'b0;
    expect_st("R5 wake sets without enable", 7'h00, 7'h40);
    wr(2'd3, 8'hBF);
    expect_st("R4 wake cleared by zero", 7'h00, 7'h00);
    wr(2'd1, 8'h0F);

    xfer_evt = 1'b1; tick(1); xfer_evt = 1'b0;
    tick(2);
    expect_st("R7 line6 from transfer flag", 7'h40, 7'h01);
    ack(3'd6);
    rtc_evt = 1'b1; tick(1); rtc_evt = 1'b0;
    tick(3);
    expect_st("R7 second source gives no edge", 7'h00, 7'h03);
    wr(2'd3, 8'hFE);
    tick(3);
    expect_st("R7 still locked with one flag left", 7'h00, 7'h02);
    wr(2'd3, 8'hFD);
    tick(2);
    xfer_evt = 1'b1; tick(1); xfer_evt = 1'b0;
    tick(2);
    expect_st("R7 line6 again after both cleared", 7'h40, 7'h01);
    ack(3'd6);
    wr(2'd3, 8'hFE);

    lock_in = 1'b1; tick(2);
    expect_st("R9 lock rise flag", 7'h00, 7'h10);
    tick(2);
    expect_st("R9 line4 from lock rise", 7'h10, 7'h10);
    ack(3'd4);
    wr(2'd3, 8'hEF);
    lock_in = 1'b0; tick(2);
    expect_st("R9 lock fall flag", 7'h00, 7'h20);
    tick(2);
    expect_st("R9 line4 from lock fall", 7'h10, 7'h20);
    ack(3'd4);
    wr(2'd3, 8'hDF);
    tick(2);

    xfer_evt = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'hFE;
    tick(1);
    xfer_evt = 1'b0; wr_en = 1'b0;
    expect_st("R6 set beats flag clear", 7'h00, 7'h01);
    tick(1);
    ack(3'd6);
    expect_st("R6 set beats acknowledge", 7'h40, 7'h01);
    ack(3'd6);
    expect_st("R3 ack after race clears", 7'h00, 7'h01);

    @(negedge clk); #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule